// File: doc/BRIEF.md
# Cascaded PCI Interrupt Aggregator

This block folds the four level-sensitive PCI interrupt lines (A, B, C and D) into one upstream interrupt request. Any line that is seen high is captured in a sticky status flag. Software controls which captured lines may raise the upstream request through per-line enable bits, and it acknowledges a line by writing a one to that line's status flag. All of this lives in one 32-bit control register, which also keeps several plain configuration fields: error-source masks, bus-master request priorities and a target-ready wait count.

An optional input stage takes the four pins of each of several expansion slots and swizzles them onto the four lines. Pin p of the k-th slot (slot number FIRST_SLOT + k) is routed to line (p + k) mod 4. The ROTATE parameter can turn this stage into straight pass-through, where pin p of every slot lands on line p. The register is written over a plain bus with a write strobe, four byte-lane enables and 32 write-data bits. The read data always shows the current register contents.

Top module: `pci_irq_cascade`

## Requirements
- R1: While reset is asserted, and right after it is released, every register bit reads 0 and `irq_cascade` is low.
- R2: Line i (A=0, B=1, C=2, D=3) has a status flag at register bit 28+i. The flag is set on the clock edge after any cycle in which the line is high, whether or not the line is enabled. It stays set until it is cleared.
- R3: A write with byte lane 3 enabled and data bit 28+i at 1 clears status flag i. A 0 in that data bit leaves the flag as it is. The clear wins over a line that is high in the same cycle, so a line that is still high sets the flag again one cycle later.
- R4: Line i has an enable bit at register bit 22+i, where 1 enables the line and 0 masks it. Bits 25 and 24 belong to byte lane 3, and bits 23 and 22 belong to byte lane 2.
- R5: `irq_cascade` is a register. It goes high one cycle after some line has both its status flag and its enable bit set, and it goes low one cycle after no line has both.
- R6: A write changes only the bytes whose lane enable is set. Lane k covers bits 8k+7 down to 8k.
- R7: These bits are plain read/write storage with no side effect: bits 27, 26 and 21..16 (error-source masks), bits 14..8 (master request priorities) and bits 3..0 (ready wait count). Bits 15 and 7..4 always read 0.
- R8: A write of 0xF000_0000 with lanes 3 and 2 enabled clears all four status flags, disables all four lines and clears the error masks. It leaves bits 15..0 unchanged.
- R9: With ROTATE=1, slot pins are concatenated as `slot_pins[4k+p]`, where k is the slot index from 0 and p is the pin (A=0 to D=3). That pin drives line (p+k) mod 4. All pins mapped to the same line are ORed together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_pins | input | NUM_SLOTS*4 | Level interrupt pins, four per slot |
| bus_we | input | 1 | Register write strobe |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current register contents |
| irq_cascade | output | 1 | Combined upstream interrupt request |

## Verification
The bench drives each of the sixteen slot pins alone and compares the flag that sets against the rotation formula. A router with a wrong offset or a reversed direction would light a neighbouring status bit. It then sweeps all 256 pairings of enable mask and line pattern. This exposes an enable with inverted polarity, a request output that ignores the mask, and an output that fails to drop after an acknowledge. Single-lane writes show whether a design lets writes leak into lanes that are not strobed, or lets reserved bits hold data. A line held high during its acknowledge must read clear for exactly one cycle and then set again: a design that gives priority to the set would never show the clear, and one that drops the line would never set again. The halfword mask-and-clear write must leave the lower half intact.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned REG_W     = 32;
   localparam int unsigned LANE_W    = 8;
   localparam int unsigned N_LANES   = REG_W / LANE_W;
   localparam int unsigned N_LINES   = 4;
   localparam int unsigned PINS_SLOT = 4;
   localparam int unsigned ST_LSB    = 28;
   localparam int unsigned EN_LSB    = 22;
   // plain storage: error masks 27,26,21..16; priorities 14..8; wait count 3..0
   localparam logic [REG_W-1:0] STORE_MASK = 32'h0C3F_7F0F;
endpackage

// File: rtl/irqc_slot_router.sv
module irqc_slot_router
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 4,
   parameter bit          ROTATE    = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SLOTS*PINS_SLOT-1:0] pins_i,
   output logic [N_LINES-1:0]             lines_o
);
   localparam int unsigned N_PINS = NUM_SLOTS * PINS_SLOT;

   generate
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("irqc_slot_router: NUM_SLOTS must be at least 1");
      end
   endgenerate

   logic [N_PINS-1:0] hit [N_LINES];

   for (genvar l = 0; l < N_LINES; l++) begin : g_line
      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
         for (genvar p = 0; p < PINS_SLOT; p++) begin : g_pin
            localparam int unsigned TGT = ROTATE ? ((p + k) % N_LINES) : p;
            if (TGT == l) begin : g_on
               assign hit[l][k*PINS_SLOT+p] = pins_i[k*PINS_SLOT+p];
            end else begin : g_off
               assign hit[l][k*PINS_SLOT+p] = 1'b0;
            end
         end
      end
      assign lines_o[l] = |hit[l];
   end

   AST_NO_SPURIOUS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_i == '0) |-> (lines_o == '0)); // R9
   AST_LINES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lines_o) <= $countones(pins_i)); // R9
endmodule

// File: rtl/irqc_line_cell.sv
module irqc_line_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic clr_i,
   input  logic en_we_i,
   input  logic en_d_i,
   output logic status_o,
   output logic enable_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o <= 1'b0;
         enable_o <= 1'b0;
      end else begin
         status_o <= clr_i ? 1'b0 : (status_o | line_i);
         if (en_we_i) enable_o <= en_d_i;
      end
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !status_o); // R3
   AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (line_i && !clr_i) |=> status_o); // R2
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o && !clr_i) |=> status_o); // R2
   AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we_i |=> $stable(enable_o)); // R4
endmodule

// File: rtl/irqc_ctrl_store.sv
module irqc_ctrl_store
   import irqc_pkg::*;
#(
   parameter logic [REG_W-1:0] KEEP_MASK = STORE_MASK
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [N_LANES-1:0] be_i,
   input  logic [REG_W-1:0]   wdata_i,
   output logic [REG_W-1:0]   q_o
);
   generate
      if (REG_W % LANE_W != 0) begin : g_bad_width
         $error("irqc_ctrl_store: register width must be whole bytes");
      end
   endgenerate

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam logic [LANE_W-1:0] LMASK = KEEP_MASK[g*LANE_W +: LANE_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o[g*LANE_W +: LANE_W] <= '0;
         else if (we_i && be_i[g])
            q_o[g*LANE_W +: LANE_W] <= wdata_i[g*LANE_W +: LANE_W] & LMASK;
      end

      AST_LANE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
         !(we_i && be_i[g]) |=> $stable(q_o[g*LANE_W +: LANE_W])); // R6
   end
endmodule

// File: rtl/pci_irq_cascade.sv
module pci_irq_cascade
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SLOTS  = 4,
   parameter int unsigned FIRST_SLOT = 9,
   parameter bit          ROTATE     = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SLOTS*PINS_SLOT-1:0] slot_pins,
   input  logic                           bus_we,
   input  logic [N_LANES-1:0]             bus_be,
   input  logic [REG_W-1:0]               bus_wdata,
   output logic [REG_W-1:0]               bus_rdata,
   output logic                           irq_cascade
);
   generate
      if (FIRST_SLOT > 31) begin : g_bad_first
         $error("pci_irq_cascade: FIRST_SLOT outside device number range");
      end
      if (FIRST_SLOT + NUM_SLOTS > 32) begin : g_bad_count
         $error("pci_irq_cascade: slots exceed device number range");
      end
   endgenerate

   logic [N_LINES-1:0] lines;
   logic [N_LINES-1:0] status;
   logic [N_LINES-1:0] enable;
   logic [REG_W-1:0]   store_q;
   logic               pend_any;

   irqc_slot_router #(
      .NUM_SLOTS (NUM_SLOTS),
      .ROTATE    (ROTATE)
   ) u_router (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_i  (slot_pins),
      .lines_o (lines)
   );

   for (genvar i = 0; i < N_LINES; i++) begin : g_cell
      localparam int unsigned SP = ST_LSB + i;
      localparam int unsigned EP = EN_LSB + i;
      irqc_line_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .line_i   (lines[i]),
         .clr_i    (bus_we && bus_be[SP/LANE_W] && bus_wdata[SP]),
         .en_we_i  (bus_we && bus_be[EP/LANE_W]),
         .en_d_i   (bus_wdata[EP]),
         .status_o (status[i]),
         .enable_o (enable[i])
      );
   end

   irqc_ctrl_store #(
      .KEEP_MASK (STORE_MASK)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bus_we),
      .be_i    (bus_be),
      .wdata_i (bus_wdata),
      .q_o     (store_q)
   );

   assign pend_any = |(status & enable);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_cascade <= 1'b0;
      else        irq_cascade <= pend_any;
   end

   always_comb begin
      bus_rdata = store_q;
      bus_rdata[ST_LSB +: N_LINES] = status;
      bus_rdata[EN_LSB +: N_LINES] = enable;
   end

   AST_OUT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      pend_any |=> irq_cascade); // R5
   AST_OUT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_any |=> !irq_cascade); // R5
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!irq_cascade && status == '0 && enable == '0)); // R1
endmodule

// File: tb/test_pci_irq_cascade.sv
module test_pci_irq_cascade;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] slot_pins = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_cascade;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   logic [31:0] m_store = '0;
   logic [3:0]  m_st = '0;
   logic [3:0]  m_en = '0;

   localparam logic [31:0] STORE_BITS = 32'h0C3F_7F0F;

   always #2 clk = ~clk;

   pci_irq_cascade i_pci_irq_cascade (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_pins   (slot_pins),
      .bus_we      (bus_we),
      .bus_be      (bus_be),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .irq_cascade (irq_cascade)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%08h exp=%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd();
      return (m_store & STORE_BITS) | {m_st, 2'b00, m_en, 22'b0};
   endfunction

   function automatic logic [3:0] route(input logic [15:0] pins);
      logic [3:0] r = '0;
      for (int k = 0; k < 4; k++)
         for (int p = 0; p < 4; p++)
            if (pins[k*4+p]) r[(p+k)%4] = 1'b1;
      return r;
   endfunction

   task automatic do_write(input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
      for (int g = 0; g < 4; g++)
         if (be[g]) m_store[g*8 +: 8] = d[g*8 +: 8];
      for (int i = 0; i < 4; i++) begin
         if (be[(22+i)/8]) m_en[i] = d[22+i];
         if (be[3] && d[28+i]) m_st[i] = 1'b0;
      end
   endtask

   task automatic pulse(input logic [15:0] v);
      @(negedge clk);
      slot_pins = v;
      @(negedge clk);
      slot_pins = '0;
      m_st = m_st | route(v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rdata in reset", bus_rdata, 32'h0);
      check("R1 irq in reset", {31'b0, irq_cascade}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rdata after reset", bus_rdata, 32'h0);
      check("R1 irq after reset", {31'b0, irq_cascade}, 32'h0);

      // R9 / R2: each pin alone, expected line by rotation formula
      for (int k = 0; k < 4; k++) begin
         for (int p = 0; p < 4; p++) begin
            do_write(4'b1000, 32'hF000_0000);
            pulse(16'(1) << (k*4+p));
            @(negedge clk);
            check("R9 rotated line", bus_rdata, exp_rd());
            check("R9 formula", {28'b0, m_st}, {28'b0, 4'(1) << ((p+k)%4)});
            check("R2 masked line no irq", {31'b0, irq_cascade}, 32'h0);
         end
      end

      // R4 / R5 / R2: all enable x line pattern pairs
      for (int e = 0; e < 16; e++) begin
         for (int l = 0; l < 16; l++) begin
            do_write(4'b1100, {4'hF, 2'b00, 4'(e), 22'b0});
            @(negedge clk);
            check("R5 irq low after clear", {31'b0, irq_cascade}, 32'h0);
            pulse({12'b0, 4'(l)});
            @(negedge clk);
            check("R2 R4 readback", bus_rdata, exp_rd());
            check("R5 irq level", {31'b0, irq_cascade}, {31'b0, |(4'(l) & 4'(e))});
         end
      end

      // R6 / R7: single-lane writes
      do_write(4'b1100, 32'hF000_0000);
      do_write(4'b0001, 32'hFFFF_FFFF);
      check("R6 R7 lane0", bus_rdata, 32'h0000_000F);
      check("R6 lane0 model", bus_rdata, exp_rd());
      do_write(4'b0010, 32'hFFFF_FFFF);
      check("R6 R7 lane1", bus_rdata, 32'h0000_7F0F);
      pulse(16'h000F);
      do_write(4'b0100, 32'hFFFF_FFFF);
      check("R6 lane2 keeps status", bus_rdata, 32'hF0FF_7F0F);
      do_write(4'b1000, 32'h0FFF_FFFF);
      check("R3 R7 lane3 zero leaves status", bus_rdata, 32'hFFFF_7F0F);
      @(negedge clk);
      check("R5 irq with all enabled", {31'b0, irq_cascade}, 32'h1);

      // R8: halfword mask-and-clear
      do_write(4'b1100, 32'hF000_0000);
      check("R8 upper cleared lower kept", bus_rdata, 32'h0000_7F0F);
      @(negedge clk);
      check("R8 irq dropped", {31'b0, irq_cascade}, 32'h0);

      // R3: clear while line still high
      do_write(4'b1000, 32'h0300_0000);
      do_write(4'b0100, 32'h00C0_0000);
      @(negedge clk);
      slot_pins = 16'h0001;
      @(negedge clk);
      check("R3 set by held line", bus_rdata[31:28], 32'h1);
      do_write(4'b1000, 32'h1300_0000);
      check("R3 clear wins this cycle", bus_rdata[31:28], 32'h0);
      @(negedge clk);
      check("R3 sets again next cycle", bus_rdata[31:28], 32'h1);
      slot_pins = '0;
      do_write(4'b1000, 32'h0300_0000);
      check("R3 zero write keeps flag", bus_rdata[31:28], 32'h1);

      // R1: reset during activity
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rdata on mid reset", bus_rdata, 32'h0);
      check("R1 irq on mid reset", {31'b0, irq_cascade}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule